// File: doc/BRIEF.md
# Banked Dual-Port Word Memory

This block is a 128-word by 8-bit memory with one write port and one read port. It is built from eight small staged-write cells, each 32 words by 4 bits. The cells are arranged as four depth banks, and each bank has two nibble lanes. Every cell sees the same low five address bits and the same control signals. The two top bits of the write address are decoded into a one-hot bank select, and that select drives the write-port enable of each cell. As a result, a write reaches the two cells of one bank only.

A write is captured on the rising edge of the clock and committed to the cell storage on the falling edge that follows. The read port is combinational. The two top bits of the read address are decoded, gated by the read enable, into one-hot drive enables for a shared read bus. When the read enable is low, no bank drives the bus. This idle state is signalled by a low output-enable flag, and the data reads as zero. That lets surrounding logic merge the read bus with the write bus.

A registered copy of the read bus and its flag is also provided. Tying the read address to the write address, bit for bit, gives a single-port memory. The ports are plain level signals with no valid/ready handshake and no back-pressure: every write completes within one cycle and every read is answered in the same cycle.

Top module: `banked_dpram`

## Requirements
- R1: The address is 7 bits wide. Bits [6:5] select one of four banks and bits [4:0] select the word inside that bank, which gives 128 distinct 8-bit words.
- R2: A write presented with `wr_en` high at a rising edge is committed at the next falling edge. A combinational read of that address returns the new word from that falling edge onward.
- R3: A write changes only the word at `wr_addr`. The same 5-bit offset in the other three banks keeps its contents.
- R4: `wr_data[3:0]` is stored in the low-nibble lane and `wr_data[7:4]` in the high-nibble lane of the selected bank. A read returns them in the same positions.
- R5: While `rd_en` is high, `rd_data` equals the word stored at `rd_addr`, and exactly one bank drives the bus.
- R6: While `rd_en` is low, `rd_data` is 0 and `rd_oe` is 0, whatever the address and the memory contents.
- R7: `rd_oe` is 1 exactly when `rd_en` is 1, with no cycle of delay.
- R8: At each rising edge, `rd_data_q` and `rd_oe_q` load the values that `rd_data` and `rd_oe` held just before that edge.
- R9: While `wr_en` is low at a rising edge, no word changes, whatever `wr_addr` and `wr_data` are.
- R10: When `rd_addr` equals `wr_addr` during a write cycle, the read returns the old word before the commit edge and the new word in the next cycle.
- R11: While `rst_n` is low, `rd_data_q` and `rd_oe_q` are 0 and any captured write is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Rising edge captures, falling edge commits writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 7 | Write address, bits [6:5] pick the bank |
| wr_data | input | 8 | Write word |
| rd_en | input | 1 | Read enable. Low releases the read bus |
| rd_addr | input | 7 | Read address, bits [6:5] pick the bank |
| rd_data | output | 8 | Combinational read bus, 0 when released |
| rd_oe | output | 1 | High while a bank drives the read bus |
| rd_data_q | output | 8 | Registered copy of the read bus |
| rd_oe_q | output | 1 | Registered copy of the output-enable flag |

## Verification
The bench writes one offset in each of the four banks in turn and reads that offset back from all four banks. A broken bank decoder would corrupt a neighbouring bank or leave the target unchanged. Fill patterns use different values in the two nibbles, so a lane swap or a shared lane shows up as a wrong word. Cycles with the address tied to itself check the read-before-commit ordering: a design that commits on the rising edge, or one delay late, returns the new word a cycle early or late. Random toggling of the read enable and long runs with the write enable low catch a bus that stays driven while released, or stray writes.

// File: rtl/bdpram_pkg.sv
package bdpram_pkg;
  localparam int unsigned DEF_CELL_AW   = 5;
  localparam int unsigned DEF_CELL_DW   = 4;
  localparam int unsigned DEF_BANK_BITS = 2;
  localparam int unsigned DEF_LANES     = 2;
endpackage

// File: rtl/bdpram_onehot_dec.sv
module bdpram_onehot_dec #(
  parameter  int unsigned CODE_W = 2,
  localparam int unsigned N      = 1 << CODE_W
) (
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  output logic [N-1:0]      hot
);
  for (genvar g = 0; g < N; g++) begin : g_out
    assign hot[g] = en && (code == CODE_W'(g));
  end
endmodule

// File: rtl/bdpram_cell.sv
module bdpram_cell #(
  parameter  int unsigned AW    = 5,
  parameter  int unsigned DW    = 4,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          wpe,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          wstb
);
  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] stage_addr;
  logic [DW-1:0] stage_data;
  logic          stage_we;

  // capture stage on the rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_we   <= 1'b0;
      stage_addr <= '0;
      stage_data <= '0;
    end else begin
      stage_we   <= we & wpe;
      stage_addr <= waddr;
      stage_data <= wdata;
    end
  end

  // commit half a cycle later
  always_ff @(negedge clk) begin
    if (stage_we) store[stage_addr] <= stage_data;
  end

  assign rdata = store[raddr];
  assign wstb  = stage_we;
endmodule

// File: rtl/bdpram_read_bus.sv
module bdpram_read_bus #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 8
) (
  input  logic [N-1:0]   drv_en,
  input  logic [N*W-1:0] src,
  output logic [W-1:0]   bus
);
  // wired-OR model of per-bank bus drivers
  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) begin
      if (drv_en[i]) bus = bus | src[i*W +: W];
    end
  end
endmodule

// File: rtl/banked_dpram.sv
module banked_dpram
  import bdpram_pkg::*;
#(
  parameter  int unsigned CELL_AW   = DEF_CELL_AW,
  parameter  int unsigned CELL_DW   = DEF_CELL_DW,
  parameter  int unsigned BANK_BITS = DEF_BANK_BITS,
  parameter  int unsigned LANES     = DEF_LANES,
  localparam int unsigned AW        = CELL_AW + BANK_BITS,
  localparam int unsigned DW        = CELL_DW * LANES,
  localparam int unsigned BANKS     = 1 << BANK_BITS,
  localparam int unsigned CELLS     = BANKS * LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_oe,
  output logic [DW-1:0] rd_data_q,
  output logic          rd_oe_q
);
  logic [BANKS-1:0]    wr_bank_sel;
  logic [BANKS-1:0]    rd_bank_sel;
  logic [BANKS*DW-1:0] bank_rdata;
  logic [CELLS-1:0]    cell_wstb;

  bdpram_onehot_dec #(.CODE_W(BANK_BITS)) u_wr_dec (
    .en   (wr_en),
    .code (wr_addr[AW-1:CELL_AW]),
    .hot  (wr_bank_sel)
  );

  bdpram_onehot_dec #(.CODE_W(BANK_BITS)) u_rd_dec (
    .en   (rd_en),
    .code (rd_addr[AW-1:CELL_AW]),
    .hot  (rd_bank_sel)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      bdpram_cell #(.AW(CELL_AW), .DW(CELL_DW)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .wpe   (wr_bank_sel[b]),
        .waddr (wr_addr[CELL_AW-1:0]),
        .wdata (wr_data[l*CELL_DW +: CELL_DW]),
        .raddr (rd_addr[CELL_AW-1:0]),
        .rdata (bank_rdata[b*DW + l*CELL_DW +: CELL_DW]),
        .wstb  (cell_wstb[b*LANES + l])
      );
    end
  end

  bdpram_read_bus #(.N(BANKS), .W(DW)) u_rd_bus (
    .drv_en (rd_bank_sel),
    .src    (bank_rdata),
    .bus    (rd_data)
  );

  assign rd_oe = |rd_bank_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
      rd_oe_q   <= 1'b0;
    end else begin
      rd_data_q <= rd_data;
      rd_oe_q   <= rd_oe;
    end
  end
endmodule

// File: rtl/banked_dpram_chk.sv
module banked_dpram_chk #(
  parameter int unsigned DW    = 8,
  parameter int unsigned BANKS = 4,
  parameter int unsigned LANES = 2,
  parameter int unsigned CELLS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [DW-1:0]    rd_data,
  input logic             rd_oe,
  input logic [DW-1:0]    rd_data_q,
  input logic             rd_oe_q,
  input logic [BANKS-1:0] wr_bank_sel,
  input logic [BANKS-1:0] rd_bank_sel,
  input logic [CELLS-1:0] cell_wstb
);
  p_one_bank_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $countones(wr_bank_sel) == 1);
  p_no_bank_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> wr_bank_sel == '0);
  p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $countones(cell_wstb) == LANES);
  p_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> cell_wstb == '0);
  p_lanes_paired_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cell_wstb) == 0) || ($countones(cell_wstb) == LANES));
  p_one_driver_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> $countones(rd_bank_sel) == 1);
  p_bus_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0) && !rd_oe && $onehot0(rd_bank_sel));
  p_oe_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe == rd_en);
  p_reg_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_data_q == $past(rd_data)) && (rd_oe_q == $past(rd_oe)));
endmodule

bind banked_dpram banked_dpram_chk #(
  .DW(DW), .BANKS(BANKS), .LANES(LANES), .CELLS(CELLS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .rd_data     (rd_data),
  .rd_oe       (rd_oe),
  .rd_data_q   (rd_data_q),
  .rd_oe_q     (rd_oe_q),
  .wr_bank_sel (wr_bank_sel),
  .rd_bank_sel (rd_bank_sel),
  .cell_wstb   (cell_wstb)
);

// File: tb/banked_dpram_test.sv
module banked_dpram_test;
  localparam int AW = 7;
  localparam int DW = 8;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data, rd_data_q;
  logic          rd_oe, rd_oe_q;

  int checks = 0;
  int errors = 0;
  bit run_checks = 1'b0;
  bit done = 1'b0;
  string tag = "R5";

  always #2 clk = ~clk;

  banked_dpram uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_oe(rd_oe), .rd_data_q(rd_data_q), .rd_oe_q(rd_oe_q)
  );

  // behavioural reference
  logic [DW-1:0] mdl [WORDS];
  bit            pend_we;
  int            pend_a;
  logic [DW-1:0] pend_d;
  logic [DW-1:0] exp_q;
  bit            exp_oe_q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_we  = 1'b0;
      exp_q    = '0;
      exp_oe_q = 1'b0;
    end else begin
      exp_q    = rd_en ? mdl[rd_addr] : '0;
      exp_oe_q = rd_en;
      pend_we  = wr_en;
      pend_a   = int'(wr_addr);
      pend_d   = wr_data;
    end
  end

  always @(negedge clk) begin
    if (pend_we) mdl[pend_a] = pend_d;
  end

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    #3;
    if (run_checks) begin
      check("R7", DW'(rd_oe), DW'(rd_en));
      check(rd_en ? tag : "R6", rd_data, rd_en ? mdl[rd_addr] : '0);
      check("R8", rd_data_q, exp_q);
      check("R8", DW'(rd_oe_q), DW'(exp_oe_q));
    end
  end

  task automatic cyc(bit we, int wa, logic [DW-1:0] wd, bit re, int ra);
    @(posedge clk);
    #1;
    wr_en = we; wr_addr = AW'(wa); wr_data = wd;
    rd_en = re; rd_addr = AW'(ra);
  endtask

  function automatic logic [DW-1:0] pat(int a);
    return DW'((a * 37 + 11) ^ (a << 4));
  endfunction

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R11", rd_data_q, '0);
    check("R11", DW'(rd_oe_q), '0);
    check("R11", DW'(rd_oe), '0);
    rst_n = 1'b1;
    run_checks = 1'b1;

    // fill every word, bus released meanwhile (R1 R4 R6)
    tag = "R2";
    for (int a = 0; a < WORDS; a++) cyc(1, a, pat(a), 0, a);
    cyc(0, 0, '0, 0, 0);

    // read every word back (R1 R4 R5)
    tag = "R1 R4 R5";
    for (int a = 0; a < WORDS; a++) cyc(0, 0, '0, 1, a);

    // bank isolation: write one offset per bank, read that offset everywhere (R3)
    tag = "R3";
    for (int b = 0; b < 4; b++) begin
      cyc(1, b * 32 + 9, DW'(8'hC3 ^ (b * 8'h11)), 1, b * 32 + 9);
      for (int k = 0; k < 4; k++) cyc(0, 0, '0, 1, k * 32 + 9);
    end

    // write enable low: nothing may change (R9)
    tag = "R9";
    for (int i = 0; i < 24; i++)
      cyc(0, int'($urandom_range(WORDS - 1)), DW'($urandom), 1, int'($urandom_range(WORDS - 1)));
    for (int a = 0; a < WORDS; a += 3) cyc(0, a, 8'hFF, 1, a);

    // tied addresses, single-port use (R10 R2)
    tag = "R10";
    for (int i = 0; i < 24; i++) begin
      int a = int'($urandom_range(WORDS - 1));
      cyc(1, a, DW'($urandom), 1, a);
    end

    // read enable toggling with traffic (R5 R6 R7)
    tag = "R5";
    for (int i = 0; i < 200; i++)
      cyc(bit'($urandom_range(1)), int'($urandom_range(WORDS - 1)), DW'($urandom),
          bit'($urandom_range(1)), int'($urandom_range(WORDS - 1)));

    // reset cancels outputs (R11)
    cyc(0, 0, '0, 1, 5);
    @(posedge clk);
    #1;
    run_checks = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R11", rd_data_q, '0);
    check("R11", DW'(rd_oe_q), '0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule